// File: doc/BRIEF.md
# Programmable Timing NCO Phase Accumulator

This block produces the sample-timing strobe of a digital receiver. A 32-bit phase accumulator adds an increment every clock and wraps modulo 2^32; each wrap gives a one-cycle run strobe that downstream filters use as their compute enable. The increment is the active center frequency plus, when enabled, a signed offset word. The offset word arrives bit by bit on a small serial stream port.

Software-side settings come in through a plain write port: address, data and a write enable. The center frequency and an 8-bit phase offset are first written to holding registers. They move to the active registers only when a strobe address is written, or when an enabled external sync edge arrives. The output phase is the top accumulator byte plus the active phase offset.

The serial offset port is valid/ready. `ser_ready` is always high, so the port never applies back-pressure: a bit is taken on every cycle that `ser_valid` is high, and the sender need not wait.

Top module: `timing_nco`

## Requirements
- R1: The accumulator adds the increment every enabled cycle, modulo 2^32. `run_strobe` is high for exactly the cycle after an addition that carried out of bit 31, so N cycles from zero give floor(N*inc/2^32) strobes.
- R2: A write to address 1 stages the center frequency. Address 3 is the frequency strobe, and its data are ignored. The staged value becomes active only on the clock of a frequency strobe write, and it is used from the following addition onward.
- R3: Control bit 2 is the offset enable. When it is set, the increment is the active center plus the offset word. When it is clear, the offset counts as zero, whatever word was loaded.
- R4: While control bit 1 (clear) is set, the accumulator is held at zero and `run_strobe` stays low.
- R5: Control bits [4:3] select the offset width: codes 00, 01, 10 and 11 give 8, 16, 24 and 32 bits. Serial bits shift in MSB first on each `ser_valid` cycle, and `ser_ready` is always 1. On the beat with `ser_last`, the low width bits collected are sign-extended to 32 bits and become the offset word.
- R6: With control bit 0 (load on update) set, a frequency update zeroes the accumulator on its clock. With the bit clear, that clock adds the old increment as usual.
- R7: A write to address 2 stages an 8-bit phase offset. It takes effect only when address 4 (phase strobe) is written. `phase_out` equals accumulator bits [31:24] plus the active offset, modulo 256, and the accumulator itself is not changed.
- R8: With control bit 5 set, a rising edge on `sync_in` performs both the frequency update and the phase update on the third clock edge after it is first sampled. With bit 5 clear, `sync_in` has no effect.
- R9: After reset, every register is zero and the accumulator is held at zero until the first frequency update. `run_strobe` and `phase_out` read 0.
- R10: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| sync_in | input | 1 | Asynchronous external sync |
| ser_valid | input | 1 | Serial offset bit valid |
| ser_ready | output | 1 | Serial port ready (always 1) |
| ser_data | input | 1 | Serial offset bit, MSB first |
| ser_last | input | 1 | Marks the final bit of an offset word |
| run_strobe | output | 1 | One-cycle pulse on accumulator wrap |
| phase_out | output | 8 | Top phase byte plus phase offset |

## Verification
The assertions assume a clean synchronous reset and at most one register write per cycle. They also assume `sync_in` is either held low or pulsed for at least one full clock, so the synchronizer sees a clean edge. Offset frames are sent with the width code already programmed. The stimulus meets these assumptions: it drives every input on the falling edge, issues one write per task call, pulses sync for a whole cycle, and sets the width code before it streams any serial bits.

// File: rtl/tnco_pkg.sv
package tnco_pkg;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_CENTER = 1;
  localparam int ADR_PHASE  = 2;
  localparam int ADR_FSTB   = 3;
  localparam int ADR_PSTB   = 4;
  localparam int CTRL_W     = 6;

  typedef struct packed {
    logic       sync_en;
    logic [1:0] wcode;
    logic       off_en;
    logic       clear;
    logic       load_upd;
  } ctrl_t;
endpackage

// File: rtl/tnco_regs.sv
module tnco_regs
  import tnco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 8,
  parameter int AW    = 3,
  parameter int SYNC_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             sync_in,
  output ctrl_t            ctrl,
  output logic [ACC_W-1:0] act_center,
  output logic [PH_W-1:0]  act_phase,
  output logic             freq_upd,
  output logic             running
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_pulse;
  logic                   phase_upd;
  logic [ACC_W-1:0]       hold_center;
  logic [PH_W-1:0]        hold_phase;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= sync_in;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_pulse = sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1] & ctrl.sync_en;
  assign freq_upd   = (wr_en && wr_addr == AW'(ADR_FSTB)) || sync_pulse;
  assign phase_upd  = (wr_en && wr_addr == AW'(ADR_PSTB)) || sync_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl        <= '0;
      hold_center <= '0;
      hold_phase  <= '0;
      act_center  <= '0;
      act_phase   <= '0;
      running     <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(ADR_CTRL))   ctrl        <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == AW'(ADR_CENTER)) hold_center <= wr_data;
      if (wr_en && wr_addr == AW'(ADR_PHASE))  hold_phase  <= wr_data[PH_W-1:0];
      if (freq_upd) begin
        act_center <= hold_center;
        running    <= 1'b1;
      end
      if (phase_upd) act_phase <= hold_phase;
    end
  end

  // R2: the active center moves only on a frequency update
  p_center_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(freq_upd) |-> $stable(act_center));
  p_center_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freq_upd) |-> act_center == $past(hold_center));
  // R7: the active phase offset moves only on a phase update
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phase_upd) |-> $stable(act_phase));
  // R9: once running, stays running
  p_running_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> running);
endmodule

// File: rtl/tnco_serial.sv
module tnco_serial #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_valid,
  input  logic             ser_data,
  input  logic             ser_last,
  input  logic [1:0]       wcode,
  output logic             ser_ready,
  output logic [ACC_W-1:0] off_word
);
  localparam int LANE = ACC_W / 4;

  logic [ACC_W-1:0] shreg;
  logic [ACC_W-1:0] shnext;
  logic             accept;

  function automatic logic [ACC_W-1:0] sext(input logic [ACC_W-1:0] v, input logic [1:0] code);
    logic [ACC_W-1:0] r;
    int w;
    w = (int'(code) + 1) * LANE;
    for (int i = 0; i < ACC_W; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  assign ser_ready = 1'b1;
  assign accept    = ser_valid & ser_ready;
  assign shnext    = {shreg[ACC_W-2:0], ser_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      off_word <= '0;
    end else if (accept) begin
      shreg <= shnext;
      if (ser_last) off_word <= sext(shnext, wcode);
    end
  end

  // R5: the offset word changes only at the end of a frame
  p_offset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_valid && ser_last) |-> $stable(off_word));
  // R5: an 8-bit frame yields a sign-extended word
  p_offset_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_valid && ser_last) && $past(wcode) == 2'd0) |->
      (off_word[ACC_W-1:LANE-1] == '0 || off_word[ACC_W-1:LANE-1] == '1));
endmodule

// File: rtl/tnco_phase_acc.sv
module tnco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  input  logic             hold,
  input  logic             load_zero,
  input  logic [PH_W-1:0]  phase_off,
  output logic             strobe,
  output logic [PH_W-1:0]  phase_out
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum       = {1'b0, acc} + {1'b0, inc};
  assign phase_out = acc[ACC_W-1 -: PH_W] + phase_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (hold || load_zero) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else begin
      acc    <= sum[ACC_W-1:0];
      strobe <= sum[ACC_W];
    end
  end

  // R1: strobe marks exactly the cycles where the accumulator wrapped
  p_wrap_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold) && !$past(load_zero)) |-> (strobe == (acc < $past(acc))));
  // R4: clear holds zero with no strobe
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> (acc == '0 && !strobe));
  // R6: load on update restarts the phase
  p_load_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_zero) |-> acc == '0);
endmodule

// File: rtl/timing_nco.sv
module timing_nco
  import tnco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             sync_in,
  input  logic             ser_valid,
  output logic             ser_ready,
  input  logic             ser_data,
  input  logic             ser_last,
  output logic             run_strobe,
  output logic [PH_W-1:0]  phase_out
);
  ctrl_t            ctrl;
  logic [ACC_W-1:0] act_center;
  logic [PH_W-1:0]  act_phase;
  logic             freq_upd;
  logic             running;
  logic [ACC_W-1:0] off_word;
  logic [ACC_W-1:0] inc;
  logic             hold;
  logic             load_zero;

  tnco_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .AW(AW), .SYNC_STAGES(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .ctrl(ctrl), .act_center(act_center), .act_phase(act_phase),
    .freq_upd(freq_upd), .running(running)
  );

  tnco_serial #(.ACC_W(ACC_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_last(ser_last), .wcode(ctrl.wcode), .ser_ready(ser_ready), .off_word(off_word)
  );

  assign inc       = act_center + (ctrl.off_en ? off_word : '0);
  assign hold      = ctrl.clear | ~running;
  assign load_zero = freq_upd & ctrl.load_upd;

  tnco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc(inc), .hold(hold), .load_zero(load_zero),
    .phase_off(act_phase), .strobe(run_strobe), .phase_out(phase_out)
  );

  // R9: no strobe before the first frequency update
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !run_strobe);
endmodule

// File: tb/sim_timing_nco.sv
module sim_timing_nco;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic        ser_valid = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_last = 1'b0;
  logic        ser_ready;
  logic        run_strobe;
  logic [7:0]  phase_out;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  timing_nco u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data),
    .ser_last(ser_last), .run_strobe(run_strobe), .phase_out(phase_out)
  );

  typedef struct packed {
    logic [31:0] inc;
    logic [15:0] n;
    logic [7:0]  strobes;
    logic [7:0]  ph;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{inc: 32'h4000_0000, n: 16'd16,  strobes: 8'd4, ph: 8'h00},
    '{inc: 32'h8000_0000, n: 16'd10,  strobes: 8'd5, ph: 8'h00},
    '{inc: 32'h1000_0000, n: 16'd40,  strobes: 8'd2, ph: 8'h80},
    '{inc: 32'h0000_0000, n: 16'd20,  strobes: 8'd0, ph: 8'h00},
    '{inc: 32'hC000_0000, n: 16'd8,   strobes: 8'd6, ph: 8'h00},
    '{inc: 32'h0100_0000, n: 16'd300, strobes: 8'd1, ph: 8'h2C}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, output int sc);
    sc = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (run_strobe) sc++;
    end
  endtask

  task automatic measure(input logic [31:0] base, input int n, input int es,
                         input logic [7:0] eph, input string tag);
    int sc;
    wr(3'd0, base | 32'h2);
    wr(3'd0, base);
    run(n, sc);
    check({tag, " strobes"}, sc, es);
    check({tag, " phase"}, {24'h0, phase_out}, {24'h0, eph});
  endtask

  task automatic send(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_valid = 1'b1; ser_data = v[i]; ser_last = (i == 0);
    end
    @(negedge clk);
    ser_valid = 1'b0; ser_last = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int sc;
    logic [7:0] p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 strobe", {31'h0, run_strobe}, 32'h0);
    check("R9 phase", {24'h0, phase_out}, 32'h0);
    check("R5 ready", {31'h0, ser_ready}, 32'h1);

    // R9 held until first update; R2 staging alone does nothing
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h4000_0000);
    run(8, sc);
    check("R9 idle strobes", sc, 0);
    check("R9 idle phase", {24'h0, phase_out}, 32'h0);
    wr(3'd3, 32'hDEAD_BEEF);
    measure(32'h0, 16, 4, 8'h00, "R2 first update");

    // R1/R2 vector table
    for (int k = 0; k < NV; k++) begin
      wr(3'd0, 32'h2);
      wr(3'd1, VECS[k].inc);
      wr(3'd3, 32'h0);
      wr(3'd0, 32'h0);
      run(int'(VECS[k].n), sc);
      check($sformatf("R1 vec%0d strobes", k), sc, int'(VECS[k].strobes));
      check($sformatf("R1 vec%0d phase", k), {24'h0, phase_out}, {24'h0, VECS[k].ph});
    end

    // R10 unmapped writes ignored
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    measure(32'h0, 300, 1, 8'h2C, "R10 unmapped");

    // R7 phase offset staged then committed
    wr(3'd2, 32'h30);
    measure(32'h0, 300, 1, 8'h2C, "R7 staged only");
    wr(3'd4, 32'h0);
    measure(32'h0, 300, 1, 8'h5C, "R7 committed");
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0);

    // R2 staged center without strobe keeps old increment
    wr(3'd1, 32'h8000_0000);
    measure(32'h0, 10, 0, 8'h0A, "R2 no strobe");

    // R6 load on update zeroes accumulator at update clock
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h0);
    check("R6 load zero", {24'h0, phase_out}, 32'h0);
    @(posedge clk); #1;
    check("R6 next add", {24'h0, phase_out}, 32'h80);
    check("R1 no wrap", {31'h0, run_strobe}, 32'h0);
    @(posedge clk); #1;
    check("R1 wrap strobe", {31'h0, run_strobe}, 32'h1);
    // R6 without load the update clock adds the old increment
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0100_0000);
    @(negedge clk);
    p0 = phase_out;
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 no load", {24'h0, phase_out}, {24'h0, 8'(p0 + 8'h80)});
    @(posedge clk); #1;
    check("R2 new inc used", {24'h0, phase_out}, {24'h0, 8'(p0 + 8'h81)});

    // R4 clear holds zero
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h2);
    run(20, sc);
    check("R4 clear strobes", sc, 0);
    check("R4 clear phase", {24'h0, phase_out}, 32'h0);
    measure(32'h0, 4, 3, 8'hFF, "R1 near-full inc");

    // R3/R5 offset word
    wr(3'd1, 32'h0200_0000);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    send(32'h80, 8);
    measure(32'h0, 256, 2, 8'h00, "R3 offset disabled");
    measure(32'h4, 256, 1, 8'hFF, "R5 8-bit negative");
    wr(3'd0, 32'h1C);
    send(32'h0100_0000, 32);
    measure(32'h1C, 10, 0, 8'h1E, "R5 32-bit");
    wr(3'd0, 32'h0C);
    send(32'hFF00, 16);
    measure(32'h0C, 256, 1, 8'hFF, "R5 16-bit");
    wr(3'd0, 32'h14);
    send(32'h80_0000, 24);
    measure(32'h14, 16, 0, 8'h18, "R5 24-bit");

    // R8 external sync: disabled has no effect
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1000_0000);
    pulse_sync();
    repeat (6) @(negedge clk);
    measure(32'h0, 16, 0, 8'h20, "R8 sync disabled");
    // R8 enabled with load: update lands on third edge
    wr(3'd0, 32'h21);
    wr(3'd1, 32'h0800_0000);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R8 sync load", {24'h0, phase_out}, 32'h0);
    @(posedge clk); #1;
    check("R8 sync new center", {24'h0, phase_out}, 32'h08);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule